// File: doc/BRIEF.md
# Reset-Time Strap Configuration Latch

This block reads start-up configuration from pins that have a second job. While the active-low release input `hold_n` is low, four fault-indicator pins and two audio data pins are treated as configuration straps. Two dedicated select pins are also read at that time. On the release edge the block stores one complete configuration: the clock source, the channel mode, a 3-bit edge-rate index and a 3-bit dead-time index. From then on the fault pins are driven as active-low outputs.

Two strap bits are read inverted, so the setting numbers do not follow the raw pin patterns in order. The channel mode also sets the role of fault pin 0. In 2-channel mode it drives a data-loss flag. In 4-channel mode it stays an input, and its level enables or disables the low-side switches.

`hold_n` and all strap pins go through the same synchronizer of `SYNC_STAGES` flops, so they stay aligned in time. One rising-edge detector then loads the whole configuration bank in a single cycle.

Top module: `strap_cfg_latch`

## Requirements
- R1: `clk_ext` takes the level of `clk_sel_pin` that was captured at release: 0 selects the internal clock and 1 selects the external clock.
- R2: `four_chan` takes the captured level of `chan_sel_pin`: 0 selects 2-channel mode and 1 selects 4-channel mode.
- R3: `edge_idx` = {err_pin_in[3], err_pin_in[2], NOT in_b_pin}. For example, pins 0,0,1 give index 0, the slowest edge.
- R4: `gap_idx` = {err_pin_in[1], err_pin_in[0], NOT in_d_pin}. For example, pins 0,0,1 give index 0, the shortest dead time.
- R5: The captured pin values are those of the last clock edge at which `hold_n` was sampled low. They appear on the outputs, together with `cfg_valid`, `SYNC_STAGES` edges after the first edge that samples `hold_n` high.
- R6: Pin changes after release leave the stored settings unchanged. The settings change only at the next release.
- R7: `cfg_valid` is 1 from capture until `SYNC_STAGES` edges after `hold_n` is first sampled low.
- R8: `err_pin_oe` is 0 on every pin whenever `hold_n` is low (this path is combinational) or `cfg_valid` is 0.
- R9: While `cfg_valid` and `hold_n` are high, `err_pin_oe[3:1]` are 1. `err_pin_oe[0]` is 1 in 2-channel mode and 0 in 4-channel mode.
- R10: One edge after it is sampled, `err_pin_out` equals the active-low inverse of `fault_flags` (bit 3 thermal shutdown, 2 thermal warning, 1 overcurrent, 0 data loss).
- R11: `lowside_en` is 1 unless `cfg_valid` and `four_chan` are both 1. In that case it follows `err_pin_in[0]` (1 enabled, 0 disabled), `SYNC_STAGES` edges later.
- R12: A synchronous `rst` clears the settings to 0 and sets `cfg_valid`=0, `lowside_en`=1, `err_pin_out`=4'b1111 and `err_pin_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Active-low reset/power-down level; the rising edge captures the straps |
| clk_sel_pin | input | 1 | Clock-source strap |
| chan_sel_pin | input | 1 | Channel-mode strap |
| err_pin_in | input | 4 | Levels read from the fault pins |
| in_b_pin | input | 1 | Audio input B, edge-rate LSB strap (inverted) |
| in_d_pin | input | 1 | Audio input D, dead-time LSB strap (inverted) |
| fault_flags | input | 4 | Internal fault conditions, active high |
| err_pin_out | output | 4 | Active-low values driven on the fault pins |
| err_pin_oe | output | 4 | Output enables for the fault pins |
| clk_ext | output | 1 | 1 = external clock selected |
| four_chan | output | 1 | 1 = 4-channel mode |
| edge_idx | output | 3 | Edge-rate setting index 0..7 |
| gap_idx | output | 3 | Dead-time setting index 0..7 |
| cfg_valid | output | 1 | Configuration captured and released |
| lowside_en | output | 1 | Low-side switch enable |

## Verification
The stored settings and `cfg_valid` are due `SYNC_STAGES` edges after the edge that first samples a change on `hold_n`. `lowside_en` follows fault pin 0 with the same delay, and `err_pin_out` one edge after `fault_flags`. `err_pin_oe` responds at once to `hold_n` going low. The bench's reference model keeps queues of past input samples that are `SYNC_STAGES` deep, and it compares every output 5 ns after each rising clock edge, once all registers have settled. Directed checks then sample the cycle before and the cycle of the capture, to pin down the latency exactly.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int CODE_W = 3;
  localparam int ERR_N  = 4;

  typedef logic [CODE_W-1:0] code_t;

  // straps as seen at the pads
  typedef struct packed {
    logic             clk_sel;
    logic             chan_sel;
    logic [ERR_N-1:0] err;
    logic             in_b;
    logic             in_d;
  } strap_pins_t;

  // stored configuration
  typedef struct packed {
    logic  clk_ext;
    logic  four_chan;
    code_t edge_idx;
    code_t gap_idx;
  } strap_cfg_t;

  // the pad feeding the low bit is read through an inverter
  function automatic code_t fold_code(input logic hi, input logic mid, input logic lo_raw);
    return {hi, mid, ~lo_raw};
  endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hold_s,
  input  strap_pins_t pins_s,
  output strap_cfg_t  cfg,
  output logic        valid
);

  logic        hold_d;
  strap_pins_t pins_d;
  logic        cap_pulse;
  strap_cfg_t  cfg_next;

  // one-cycle delay: pins_d holds the last low-phase sample on the release cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_d <= 1'b0;
      pins_d <= '0;
    end else begin
      hold_d <= hold_s;
      pins_d <= pins_s;
    end
  end

  assign cap_pulse = hold_s & ~hold_d;

  always_comb begin
    cfg_next.clk_ext   = pins_d.clk_sel;
    cfg_next.four_chan = pins_d.chan_sel;
    cfg_next.edge_idx  = fold_code(pins_d.err[3], pins_d.err[2], pins_d.in_b);
    cfg_next.gap_idx   = fold_code(pins_d.err[1], pins_d.err[0], pins_d.in_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      valid <= 1'b0;
    end else begin
      if (cap_pulse) cfg <= cfg_next;
      if (cap_pulse)   valid <= 1'b1;
      else if (!hold_s) valid <= 1'b0;
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cap_pulse |=> $stable(cfg)); // R6
  AST_VALID_FROM_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(cap_pulse)); // R7
  AST_CAPTURE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    cap_pulse |=> !cap_pulse); // R5

endmodule

// File: rtl/strap_pin_dir.sv
module strap_pin_dir
  import strap_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_n,
  input  logic             valid,
  input  logic             four_chan,
  input  logic             err0_s,
  input  logic [ERR_N-1:0] faults,
  output logic [ERR_N-1:0] err_out,
  output logic [ERR_N-1:0] err_oe,
  output logic             lowside_en
);

  logic [ERR_N-1:0] role_mask;

  for (genvar i = 0; i < ERR_N; i++) begin : g_role
    if (i == 0) begin : g_dual
      assign role_mask[i] = ~four_chan;
    end else begin : g_fixed
      assign role_mask[i] = 1'b1;
    end
  end

  assign err_oe = role_mask & {ERR_N{valid & hold_n}};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_out    <= '1;
      lowside_en <= 1'b1;
    end else begin
      err_out    <= ~faults;
      lowside_en <= (valid & four_chan) ? err0_s : 1'b1;
    end
  end

  AST_DUAL_ROLE_INPUT: assert property (@(posedge clk) disable iff (rst)
    (valid && four_chan) |-> !err_oe[0]); // R9
  AST_LOWSIDE_TWO_CHAN: assert property (@(posedge clk) disable iff (rst)
    !four_chan |=> lowside_en); // R11
  AST_ERR_ACTIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_out == ~$past(faults))); // R10

endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_n,
  input  logic              clk_sel_pin,
  input  logic              chan_sel_pin,
  input  logic [ERR_N-1:0]  err_pin_in,
  input  logic              in_b_pin,
  input  logic              in_d_pin,
  input  logic [ERR_N-1:0]  fault_flags,
  output logic [ERR_N-1:0]  err_pin_out,
  output logic [ERR_N-1:0]  err_pin_oe,
  output logic              clk_ext,
  output logic              four_chan,
  output logic [CODE_W-1:0] edge_idx,
  output logic [CODE_W-1:0] gap_idx,
  output logic              cfg_valid,
  output logic              lowside_en
);

  localparam int PIN_W  = $bits(strap_pins_t);
  localparam int SYNC_W = PIN_W + 1;

  strap_pins_t       pins_raw;
  strap_pins_t       pins_s;
  logic              hold_s;
  logic [SYNC_W-1:0] sync_q;
  strap_cfg_t        cfg;

  always_comb begin
    pins_raw.clk_sel  = clk_sel_pin;
    pins_raw.chan_sel = chan_sel_pin;
    pins_raw.err      = err_pin_in;
    pins_raw.in_b     = in_b_pin;
    pins_raw.in_d     = in_d_pin;
  end

  strap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_n, pins_raw}),
    .q   (sync_q)
  );

  assign hold_s = sync_q[SYNC_W-1];
  assign pins_s = sync_q[PIN_W-1:0];

  strap_capture u_capture (
    .clk    (clk),
    .rst    (rst),
    .hold_s (hold_s),
    .pins_s (pins_s),
    .cfg    (cfg),
    .valid  (cfg_valid)
  );

  strap_pin_dir u_pin_dir (
    .clk        (clk),
    .rst        (rst),
    .hold_n     (hold_n),
    .valid      (cfg_valid),
    .four_chan  (cfg.four_chan),
    .err0_s     (pins_s.err[0]),
    .faults     (fault_flags),
    .err_out    (err_pin_out),
    .err_oe     (err_pin_oe),
    .lowside_en (lowside_en)
  );

  assign clk_ext   = cfg.clk_ext;
  assign four_chan = cfg.four_chan;
  assign edge_idx  = cfg.edge_idx;
  assign gap_idx   = cfg.gap_idx;

  AST_OE_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hold_n |-> (err_pin_oe == '0)); // R8

endmodule

// File: tb/strap_cfg_latch_tb.sv
`timescale 1ns/1ps
module strap_cfg_latch_tb_top;

  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_n = 1'b0;
  logic       clk_sel_pin = 1'b0, chan_sel_pin = 1'b0;
  logic [3:0] err_pin_in = 4'h0;
  logic       in_b_pin = 1'b0, in_d_pin = 1'b0;
  logic [3:0] fault_flags = 4'h0;
  logic [3:0] err_pin_out, err_pin_oe;
  logic       clk_ext, four_chan, cfg_valid, lowside_en;
  logic [2:0] edge_idx, gap_idx;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  strap_cfg_latch #(.SYNC_STAGES(S)) dut_i (
    .clk(clk), .rst(rst), .hold_n(hold_n), .clk_sel_pin(clk_sel_pin),
    .chan_sel_pin(chan_sel_pin), .err_pin_in(err_pin_in), .in_b_pin(in_b_pin),
    .in_d_pin(in_d_pin), .fault_flags(fault_flags), .err_pin_out(err_pin_out),
    .err_pin_oe(err_pin_oe), .clk_ext(clk_ext), .four_chan(four_chan),
    .edge_idx(edge_idx), .gap_idx(gap_idx), .cfg_valid(cfg_valid),
    .lowside_en(lowside_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: input history in queues, pin vector {clk,chan,e3,e2,e1,e0,b,d}
  bit       hq[$];
  bit [7:0] pq[$];
  bit       m_clk, m_four, m_valid, m_low;
  bit [2:0] m_edge, m_gap;
  bit [3:0] m_eout;

  always @(posedge clk) begin
    if (rst) begin
      hq.delete(); pq.delete();
      for (int k = 0; k < S + 1; k++) begin hq.push_back(1'b0); pq.push_back(8'h00); end
      {m_clk, m_four, m_valid} = 3'b000;
      m_edge = 3'd0; m_gap = 3'd0; m_low = 1'b1; m_eout = 4'hF;
    end else begin
      bit hs, hd, nlow;
      bit [7:0] ps, pd;
      hq.push_back(hold_n);
      pq.push_back({clk_sel_pin, chan_sel_pin, err_pin_in, in_b_pin, in_d_pin});
      if (hq.size() > S + 2) begin void'(hq.pop_front()); void'(pq.pop_front()); end
      hs = hq[hq.size() - 1 - S];
      hd = hq[hq.size() - 2 - S];
      ps = pq[pq.size() - 1 - S];
      pd = pq[pq.size() - 2 - S];
      nlow = (m_valid && m_four) ? ps[2] : 1'b1;
      if (hs && !hd) begin
        m_clk  = pd[7];
        m_four = pd[6];
        m_edge = {pd[5], pd[4], !pd[1]};
        m_gap  = {pd[3], pd[2], !pd[0]};
        m_valid = 1'b1;
      end else if (!hs) begin
        m_valid = 1'b0;
      end
      m_low  = nlow;
      m_eout = ~fault_flags;
    end
  end

  always @(posedge clk) begin
    #5;
    chk("R1 clk_ext", clk_ext, m_clk);
    chk("R2 four_chan", four_chan, m_four);
    chk("R3 edge_idx", edge_idx, m_edge);
    chk("R4 gap_idx", gap_idx, m_gap);
    chk("R7 cfg_valid", cfg_valid, m_valid);
    chk("R8/R9 err_pin_oe", err_pin_oe,
        (m_valid && hold_n) ? {3'b111, !m_four} : 4'b0000);
    chk("R10 err_pin_out", err_pin_out, m_eout);
    chk("R11 lowside_en", lowside_en, m_low);
  end

  task automatic set_straps(input bit cs, input bit ch, input bit [3:0] e, input bit b, input bit d);
    @(negedge clk);
    clk_sel_pin = cs; chan_sel_pin = ch; err_pin_in = e; in_b_pin = b; in_d_pin = d;
  endtask

  task automatic release_and_wait();
    @(negedge clk) hold_n = 1'b1;
    @(posedge clk);
    repeat (S - 1) @(posedge clk);
    #5 chk("R5 not yet captured", cfg_valid, 1'b0);
    @(posedge clk);
    #5 chk("R5 captured on time", cfg_valid, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    n_errs++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R12 reset valid", cfg_valid, 0);
    chk("R12 reset oe", err_pin_oe, 0);
    chk("R12 reset eout", err_pin_out, 4'hF);
    chk("R12 reset lowside", lowside_en, 1);
    @(negedge clk) rst = 1'b0;

    // 2-channel, external clock, slowest edge / shortest gap
    set_straps(1, 0, 4'b0000, 1, 1);
    repeat (4) @(negedge clk);
    release_and_wait();
    #1;
    chk("R1 external", clk_ext, 1);
    chk("R3 slowest edge", edge_idx, 0);
    chk("R4 shortest gap", gap_idx, 0);
    chk("R9 all driven 2ch", err_pin_oe, 4'b1111);
    // straps move after release: must be ignored
    set_straps(0, 1, 4'b1111, 0, 0);
    fault_flags = 4'b1010;
    repeat (6) @(posedge clk);
    #5;
    chk("R6 edge held", edge_idx, 0);
    chk("R6 mode held", four_chan, 0);
    chk("R10 fault drive", err_pin_out, 4'b0101);

    // back into hold: enables drop at once
    @(negedge clk) hold_n = 1'b0;
    #1 chk("R8 oe off in hold", err_pin_oe, 0);
    set_straps(0, 1, 4'b1010, 0, 1);
    repeat (4) @(negedge clk);
    release_and_wait();
    #1;
    chk("R2 four channel", four_chan, 1);
    chk("R3 code 5", edge_idx, 5);
    chk("R4 code 4", gap_idx, 4);
    chk("R9 dual pin input", err_pin_oe, 4'b1110);
    @(negedge clk) err_pin_in[0] = 1'b0;
    repeat (S + 1) @(posedge clk);
    #5 chk("R11 lowside disabled", lowside_en, 0);
    @(negedge clk) err_pin_in[0] = 1'b1;
    repeat (S + 1) @(posedge clk);
    #5 chk("R11 lowside enabled", lowside_en, 1);

    // short hold glitch and a third pattern
    set_straps(0, 0, 4'b1111, 0, 0);
    @(negedge clk) hold_n = 1'b0;
    @(negedge clk) hold_n = 1'b1;
    repeat (S + 4) @(posedge clk);
    #5;
    chk("R3 code 7", edge_idx, 7);
    chk("R4 code 7", gap_idx, 7);
    fault_flags = 4'b0110;

    // mid-run reset
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #5;
    chk("R12 clear edge", edge_idx, 0);
    chk("R12 clear valid", cfg_valid, 0);
    @(negedge clk) rst = 1'b0;
    repeat (S + 4) @(posedge clk);
    #5 chk("R5 recapture after reset", cfg_valid, 1);

    repeat (5) @(posedge clk);
    #6;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule